// File: doc/BRIEF.md
# Serial SAR ADC Host Controller

This block is the host-side master for an external four-input serial successive-approximation converter. A client asks for a conversion on a one-cycle request port. The request carries a channel number, an input-mode flag (single-ended against the common pin, or differential pair), a short-result flag and a power-down code. The controller drops chip select and generates the serial clock by dividing the system clock. It sends an 8-bit control word MSB first and then keeps clocking while the converter works. The converter's own serial clock paces the conversion, so every frame is exactly 24 serial clocks long: three groups of eight.

The result comes back MSB first on the converter's data-out line. The first result bit is taken at rising edge 10 and the last at rising edge 21. The last three clocks carry zeros. The controller then raises chip select and presents the result with a one-cycle valid strobe. In short mode it returns the first eight result bits, zero-extended. Short mode applies only when the converter's hardware width-select pin is high. The controller also drives the converter's active-low power-down pin from a level input. The bit positions of the control word are parameters.

Top module: `sar_adc_host`

## Requirements
- R1: While reset is held and on the first cycle after it, cs_n is 1, sclk is 0, busy is 0 and res_valid is 0.
- R2: Each frame has exactly 24 rising edges of sclk, all while cs_n is 0. sclk is 0 whenever cs_n is 1.
- R3: The control word is the sdi level at rising edges 1 to 8, sent MSB first. With the default layout it is: bit 7 = 1 (start), bits 6:5 = req_chan, bit 4 = 0, bit 3 = req_res8, bit 2 = 1 for single-ended and 0 for differential (the inverse of req_diff), bits 1:0 = req_pd.
- R4: sdi changes only on falling edges of sclk. It is stable on every rising edge during a frame.
- R5: With req_res8 = 0, res_data is the 12 sdo values sampled at rising edges 10 to 21, MSB first.
- R6: With req_res8 = 1 and adc_mode = 1, res_data[7:0] holds the sdo values from rising edges 10 to 17, MSB first, and res_data[11:8] is 0.
- R7: With adc_mode = 0, the result is 12 bits as in R5, whatever req_res8 is. The control word still carries req_res8.
- R8: cs_n is 0 for at least CLK_DIV/2 system cycles before the first rising edge of sclk. It stays 0 for at least CLK_DIV/2 cycles after the last rising edge.
- R9: busy is 1 from the cycle cs_n falls until the cycle of res_valid. A req_valid seen while busy is 1 starts no frame and does not change the frame in progress.
- R10: shdn_n equals the inverse of pwr_down, one cycle later.
- R11: res_valid is a single-cycle pulse, given with cs_n = 1 and busy = 0. sdo is ignored while cs_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle conversion request |
| req_chan | input | CH_W | Channel, or differential pair, number |
| req_diff | input | 1 | 1 = differential input, 0 = single-ended |
| req_res8 | input | 1 | 1 = short 8-bit result requested |
| req_pd | input | PD_W | Power-down code placed in the control word |
| adc_mode | input | 1 | Level on the converter's width-select pin |
| pwr_down | input | 1 | 1 = hold the converter in low-power state |
| sdo | input | 1 | Converter serial data out |
| busy | output | 1 | Frame in progress |
| res_valid | output | 1 | Result strobe |
| res_data | output | RES_W | Conversion result, zero-extended in short mode |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock, idle low |
| sdi | output | 1 | Serial data to the converter |
| shdn_n | output | 1 | Converter power-down, active low |

## Verification
The assertions assume the following:
- CLK_DIV is even and at least 4, so each sclk phase lasts two or more system cycles.
- adc_mode stays steady for the whole of a frame.
- sdo changes only after a falling sclk edge.

The bench stays within these limits in three ways:
- Its converter model runs at the negative system-clock edge and updates sdo only after it sees sclk fall.
- It changes adc_mode only between frames.
- It drives random noise on sdo while chip select is high, to exercise R11.

The random requests and codes come from a fixed seed. Directed cases are mixed in: all-ones and all-zero codes, a lone MSB, a lone LSB, and a request made in the middle of a frame.

// File: rtl/sar_host_pkg.sv
package sar_host_pkg;

  // Frame sequencer states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_CLOCK,
    ST_TRAIL,
    ST_DONE
  } seq_state_t;

endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  // a phase lasts at least two system cycles
  assert_tick_gap_R8: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/sar_ctrl_fmt.sv
module sar_ctrl_fmt #(
  parameter int BYTE_W    = 8,
  parameter int CH_W      = 2,
  parameter int PD_W      = 2,
  parameter int POS_START = 7,
  parameter int POS_CHAN  = 5,
  parameter int POS_RES   = 3,
  parameter int POS_SGL   = 2,
  parameter int POS_PD    = 0
) (
  input  logic [CH_W-1:0]   chan,
  input  logic              diff,
  input  logic              res8,
  input  logic [PD_W-1:0]   pd,
  output logic [BYTE_W-1:0] ctrl
);
  always_comb begin
    ctrl                   = '0;
    ctrl[POS_START]        = 1'b1;
    ctrl[POS_CHAN +: CH_W] = chan;
    ctrl[POS_RES]          = res8;
    ctrl[POS_SGL]          = ~diff;
    ctrl[POS_PD +: PD_W]   = pd;
  end
endmodule

// File: rtl/sar_rx_shift.sv
module sar_rx_shift #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst) word <= '0;
    else if (shift) word <= {word[W-2:0], bit_in};
  end
endmodule

// File: rtl/sar_adc_host.sv
module sar_adc_host
  import sar_host_pkg::*;
#(
  parameter int CLK_DIV        = 8,
  parameter int RES_W          = 12,
  parameter int NARROW_W       = 8,
  parameter int CH_W           = 2,
  parameter int PD_W           = 2,
  parameter int BYTE_W         = 8,
  parameter int FRAME_RISES    = 24,
  parameter int FIRST_RES_RISE = 10,
  parameter int POS_START      = 7,
  parameter int POS_CHAN       = 5,
  parameter int POS_RES        = 3,
  parameter int POS_SGL        = 2,
  parameter int POS_PD         = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [CH_W-1:0]  req_chan,
  input  logic             req_diff,
  input  logic             req_res8,
  input  logic [PD_W-1:0]  req_pd,
  input  logic             adc_mode,
  input  logic             pwr_down,
  input  logic             sdo,
  output logic             busy,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data,
  output logic             cs_n,
  output logic             sclk,
  output logic             sdi,
  output logic             shdn_n
);
  localparam int HALF   = CLK_DIV / 2;
  localparam int RISE_W = $clog2(FRAME_RISES + 1);
  localparam logic [RISE_W-1:0] LAST_RISE = RISE_W'(FRAME_RISES);
  // rises holds the count before the edge being made
  localparam logic [RISE_W-1:0] SAMP_LO = RISE_W'(FIRST_RES_RISE - 1);
  localparam logic [RISE_W-1:0] SAMP_HI = RISE_W'(FIRST_RES_RISE + RES_W - 2);

  seq_state_t        state;
  logic [RISE_W-1:0] rises;
  logic [BYTE_W-1:0] tx_sr;
  logic              narrow;
  logic              tick;
  logic              run;
  logic              sample_en;
  logic [BYTE_W-1:0] ctrl_byte;
  logic [RES_W-1:0]  rx_word;
  logic [RES_W-1:0]  short_word;

  assign run = (state != ST_IDLE);

  sar_clk_div #(.HALF(HALF)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  sar_ctrl_fmt #(
    .BYTE_W(BYTE_W), .CH_W(CH_W), .PD_W(PD_W),
    .POS_START(POS_START), .POS_CHAN(POS_CHAN), .POS_RES(POS_RES),
    .POS_SGL(POS_SGL), .POS_PD(POS_PD)
  ) u_fmt (
    .chan (req_chan),
    .diff (req_diff),
    .res8 (req_res8),
    .pd   (req_pd),
    .ctrl (ctrl_byte)
  );

  // capture on the system cycle that raises sclk
  assign sample_en = tick && (state == ST_CLOCK) && !sclk &&
                     (rises >= SAMP_LO) && (rises <= SAMP_HI);

  sar_rx_shift #(.W(RES_W)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .shift  (sample_en),
    .bit_in (sdo),
    .word   (rx_word)
  );

  generate
    if (NARROW_W < RES_W) begin : g_zext
      assign short_word = {{(RES_W-NARROW_W){1'b0}}, rx_word[RES_W-1 -: NARROW_W]};
    end else begin : g_full
      assign short_word = rx_word;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cs_n      <= 1'b1;
      sclk      <= 1'b0;
      sdi       <= 1'b0;
      tx_sr     <= '0;
      rises     <= '0;
      busy      <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
      narrow    <= 1'b0;
      shdn_n    <= 1'b1;
    end else begin
      res_valid <= 1'b0;
      shdn_n    <= ~pwr_down;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cs_n   <= 1'b0;
            busy   <= 1'b1;
            sdi    <= ctrl_byte[BYTE_W-1];
            tx_sr  <= {ctrl_byte[BYTE_W-2:0], 1'b0};
            rises  <= '0;
            narrow <= adc_mode && req_res8;
            state  <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            sclk  <= 1'b1;
            rises <= rises + 1'b1;
            state <= ST_CLOCK;
          end
        end
        ST_CLOCK: begin
          if (tick) begin
            if (sclk) begin
              sclk <= 1'b0;
              if (rises == LAST_RISE) begin
                state <= ST_TRAIL;
              end else begin
                sdi   <= tx_sr[BYTE_W-1];
                tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
              end
            end else begin
              sclk  <= 1'b1;
              rises <= rises + 1'b1;
            end
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            cs_n  <= 1'b1;
            sdi   <= 1'b0;
            state <= ST_DONE;
          end
        end
        ST_DONE: begin
          res_valid <= 1'b1;
          busy      <= 1'b0;
          res_data  <= narrow ? short_word : rx_word;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  assert_rise_cap_R2: assert property (@(posedge clk) disable iff (rst)
    rises <= LAST_RISE);
  assert_sdi_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $rose(sclk)) |-> $stable(sdi));
  assert_busy_frame_R9: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy);
  assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  assert_valid_idle_R11: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (cs_n && !busy));
endmodule

// File: tb/sar_adc_host_test.sv
module sar_adc_host_test;
  localparam int CLK_DIV = 8;
  localparam int HALF    = CLK_DIV / 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_chan = '0;
  logic        req_diff = 1'b0;
  logic        req_res8 = 1'b0;
  logic [1:0]  req_pd = '0;
  logic        adc_mode = 1'b0;
  logic        pwr_down = 1'b0;
  logic        sdo = 1'b0;
  logic        busy, res_valid, cs_n, sclk, sdi, shdn_n;
  logic [11:0] res_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sar_adc_host #(.CLK_DIV(CLK_DIV)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan),
    .req_diff(req_diff), .req_res8(req_res8), .req_pd(req_pd),
    .adc_mode(adc_mode), .pwr_down(pwr_down), .sdo(sdo), .busy(busy),
    .res_valid(res_valid), .res_data(res_data), .cs_n(cs_n), .sclk(sclk),
    .sdi(sdi), .shdn_n(shdn_n)
  );

  // converter model, evaluated away from the active edge
  logic [11:0] adc_code = '0;
  logic [7:0]  m_byte = '0;
  int m_rises = 0, m_falls = 0, m_lead = 0, m_trail = 0, m_since = 0, frames = 0;
  logic prev_sclk = 1'b0, prev_cs = 1'b1;

  always @(negedge clk) begin
    if (!cs_n && prev_cs) begin
      m_rises = 0; m_falls = 0; m_byte = '0; m_lead = 0; m_since = 0;
      frames++;
    end
    if (!cs_n) begin
      if (sclk && !prev_sclk) begin
        m_rises++;
        if (m_rises <= 8) m_byte = {m_byte[6:0], sdi};
        m_since = 0;
      end else if (!sclk && prev_sclk) begin
        m_falls++;
        sdo = (m_falls >= 9 && m_falls <= 20) ? adc_code[20 - m_falls] : 1'b0;
      end
      if (m_rises == 0 && !sclk) m_lead++;
      m_since++;
    end else begin
      if (!prev_cs) m_trail = m_since;
      sdo = 1'($urandom_range(0, 1));
    end
    prev_sclk = sclk;
    prev_cs = cs_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [1:0] ch, input logic df,
                                          input logic r8, input logic [1:0] pd);
    return {1'b1, ch, 1'b0, r8, ~df, pd};
  endfunction

  function automatic logic [11:0] exp_result(input logic [11:0] code,
                                             input logic md, input logic r8);
    return (md && r8) ? {4'b0, code[11:4]} : code;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic convert(input logic [1:0] ch, input logic df, input logic r8,
                         input logic [1:0] pd, input logic md,
                         input logic [11:0] code, input bit poke);
    int fr0;
    int waited;
    string tag;
    logic [11:0] got;
    @(negedge clk);
    adc_mode = md; adc_code = code;
    req_chan = ch; req_diff = df; req_res8 = r8; req_pd = pd; req_valid = 1'b1;
    fr0 = frames;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1 && cs_n === 1'b0, "R9 busy at start", busy, 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      req_chan = ~ch; req_pd = ~pd; req_valid = 1'b1;   // R9: must be ignored
      @(negedge clk);
      req_valid = 1'b0;
    end
    waited = 0;
    while (res_valid !== 1'b1 && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    got = res_data;
    tag = (md && r8) ? "R6 short result" : (r8 ? "R7 width pin low" : "R5 full result");
    chk(got === exp_result(code, md, r8), tag, got, exp_result(code, md, r8));
    chk(m_byte === exp_byte(ch, df, r8, pd), "R3 control word", m_byte, exp_byte(ch, df, r8, pd));
    chk(m_rises == 24, "R2 rise count", m_rises, 24);
    chk(m_lead >= HALF && m_trail >= HALF, "R8 select margins", m_lead * 256 + m_trail, HALF);
    chk(cs_n === 1'b1 && busy === 1'b0, "R11 idle at valid", {cs_n, busy}, 2);
    @(negedge clk);
    chk(res_valid === 1'b0, "R11 single pulse", res_valid, 0);
    if (poke) begin
      repeat (3 * CLK_DIV) @(negedge clk);
      chk(frames == fr0 + 1 && cs_n === 1'b1, "R9 request while busy ignored", frames - fr0, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd20240917);
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0 && busy === 1'b0 && res_valid === 1'b0,
        "R1 reset state", {cs_n, sclk, busy, res_valid}, 8);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0 && busy === 1'b0 && res_valid === 1'b0,
        "R1 after reset", {cs_n, sclk, busy, res_valid}, 8);

    // R10 shutdown level
    pwr_down = 1'b1;
    repeat (2) @(negedge clk);
    chk(shdn_n === 1'b0, "R10 shutdown asserted", shdn_n, 0);
    pwr_down = 1'b0;
    repeat (2) @(negedge clk);
    chk(shdn_n === 1'b1, "R10 shutdown released", shdn_n, 1);

    // directed corners
    convert(2'd0, 1'b0, 1'b0, 2'd3, 1'b1, 12'hFFF, 0);
    convert(2'd3, 1'b1, 1'b0, 2'd0, 1'b0, 12'h000, 0);
    convert(2'd1, 1'b0, 1'b0, 2'd1, 1'b1, 12'h800, 0);
    convert(2'd2, 1'b1, 1'b0, 2'd2, 1'b1, 12'h001, 0);
    convert(2'd1, 1'b0, 1'b1, 2'd0, 1'b1, 12'hA5F, 0);  // R6 low nibble dropped
    convert(2'd2, 1'b0, 1'b1, 2'd3, 1'b0, 12'hA5F, 0);  // R7 forced full width
    convert(2'd3, 1'b1, 1'b0, 2'd1, 1'b1, 12'h5A3, 1);  // R9 mid-frame request

    // random mix
    for (int i = 0; i < 40; i++) begin
      convert(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
              1'($urandom_range(0, 1)), 12'($urandom_range(0, 4095)),
              (i % 10) == 0);
    end
    finish_run();
  end
endmodule